// File: doc/BRIEF.md
# Broadcast-Input Multiply-Accumulate Neuron Array

This block is an array of fixed-point processing elements that all consume the same signed input word, taken from one shared broadcast bus. Each element owns a private bank of signed weights. All banks are indexed by one common weight pointer. On a compute command, every element multiplies the broadcast word by the weight under the pointer and adds the product into its own wide accumulator. A vector-times-matrix product is therefore built up one input word per command, with one column per element.

An external sequencer drives the block with one command per cycle, made of a valid strobe, a 4-bit opcode and an 8-bit argument. The commands place or advance the pointer, write one weight into a chosen element's bank, clear the accumulators, run a multiply-accumulate step with or without a pointer advance, and snapshot every accumulator into a per-element result register. All result registers are visible together on one flat output bus.

Top module: `bcast_mac_array`

## Requirements
- R1: After reset, the pointer `wAddr` is 0 and every result slice on `resultBus` is 0.
- R2: Opcode 1 (set pointer) loads `cmdArg` into `wAddr`, and the new value is visible from the next cycle.
- R3: Opcode 2 (advance) adds one to `wAddr`. The pointer wraps from 255 to 0.
- R4: Opcode 3 (weight write) stores `wrData` in the bank of element number `cmdArg`, at the entry under the current pointer. The banks of all other elements are left unchanged. An element number of NEURONS or more writes nothing.
- R5: Opcode 6 (compute) adds to each element's accumulator the product of `dataIn` and the weight under the current pointer. Both operands are two's complement, and the product is sign-extended to 34 bits. The pointer does not move.
- R6: Opcode 7 (compute and advance) does the work of R5 using the weight under the pointer as it was before the command. In the same cycle the pointer advances by one, with the wrap of R3.
- R7: Opcode 4 (clear) sets every accumulator to zero.
- R8: Opcode 5 (snapshot) copies each accumulator into its result register. Element i appears at `resultBus[34*i+33 : 34*i]` from the next cycle. Result registers change on no other command.
- R9: Accumulation wraps modulo 2^34 and does not saturate.
- R10: When `cmdValid` is low, or the opcode is 0 or 8 to 15, the pointer, the weights, the accumulators and the results are all unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Command opcode |
| cmdArg | input | 8 | Pointer value or element number |
| dataIn | input | 16 | Broadcast input word, two's complement |
| wrData | input | 10 | Weight to write, two's complement |
| wAddr | output | 8 | Shared weight pointer |
| resultBus | output | 136 | Result registers of all elements, concatenated |

## Verification
The assertions take for granted that the opcode and argument are driven to known values whenever `cmdValid` is high. They also assume that a snapshot is the only way the result bus can change, so they never attempt to predict accumulator values. The stimulus changes inputs only on the falling edge and holds them for one full cycle. It issues opcodes only from the listed set, plus a deliberate undefined opcode and a deliberately idle cycle, and it runs compute commands only at pointer values whose weights it has already written for every element.

// File: rtl/bmac_pkg.sv
package bmac_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_SET_ADDR = 4'd1,
    OP_ADVANCE  = 4'd2,
    OP_WR_W     = 4'd3,
    OP_CLEAR    = 4'd4,
    OP_SNAP     = 4'd5,
    OP_MAC      = 4'd6,
    OP_MAC_ADV  = 4'd7
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic mac;
    logic clear;
    logic snap;
    logic wrW;
  } dp_strobe_t;

endpackage

// File: rtl/bmac_ctrl.sv
module bmac_ctrl
  import bmac_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdArg,
  output logic [ADDR_W-1:0] addr,
  output dp_strobe_t        stb
);

  logic setAddr;
  logic advance;

  always_comb begin
    stb     = '0;
    setAddr = 1'b0;
    advance = 1'b0;
    if (cmdValid) begin
      case (op_e'(cmdOp))
        OP_SET_ADDR: setAddr = 1'b1;
        OP_ADVANCE:  advance = 1'b1;
        OP_WR_W:     stb.wrW = 1'b1;
        OP_CLEAR:    stb.clear = 1'b1;
        OP_SNAP:     stb.snap = 1'b1;
        OP_MAC:      stb.mac = 1'b1;
        OP_MAC_ADV: begin
          stb.mac = 1'b1;
          advance = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // shared pointer, wraps naturally at 2**ADDR_W
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        addr <= '0;
    else if (setAddr) addr <= cmdArg;
    else if (advance) addr <= addr + 1'b1;
  end

endmodule

// File: rtl/bmac_datapath.sv
module bmac_datapath
  import bmac_pkg::*;
#(
  parameter int NEURONS  = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int WEIGHT_W = 10,
  parameter int ACC_W    = 34
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_strobe_t               stb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-1:0]        wrSel,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic [WEIGHT_W-1:0]      wrData,
  output logic [NEURONS*ACC_W-1:0] resultBus
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PROD_W = DATA_W + WEIGHT_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  for (genvar i = 0; i < NEURONS; i++) begin : g_neuron
    logic [WEIGHT_W-1:0] wMem [DEPTH];
    logic [ACC_W-1:0]    acc;
    logic [ACC_W-1:0]    res;
    logic signed [PROD_W-1:0] prod;
    logic                wrHit;

    assign wrHit = stb.wrW && (wrSel == ADDR_W'(i));
    assign prod  = $signed(dataIn) * $signed(wMem[addr]);

    always_ff @(posedge clk) begin
      if (wrHit) wMem[addr] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc <= '0;
        res <= '0;
      end else begin
        if (stb.clear)    acc <= '0;
        else if (stb.mac) acc <= acc + {{EXT_W{prod[PROD_W-1]}}, prod};
        if (stb.snap)     res <= acc;
      end
    end

    assign resultBus[i*ACC_W +: ACC_W] = res;
  end

endmodule

// File: rtl/bcast_mac_array.sv
module bcast_mac_array
  import bmac_pkg::*;
#(
  parameter int NEURONS  = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int WEIGHT_W = 10,
  parameter int ACC_W    = 34
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [3:0]               cmdOp,
  input  logic [ADDR_W-1:0]        cmdArg,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic [WEIGHT_W-1:0]      wrData,
  output logic [ADDR_W-1:0]        wAddr,
  output logic [NEURONS*ACC_W-1:0] resultBus
);

  dp_strobe_t stb;

  bmac_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .addr(wAddr), .stb(stb)
  );

  bmac_datapath #(
    .NEURONS(NEURONS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(wAddr), .wrSel(cmdArg),
    .dataIn(dataIn), .wrData(wrData), .resultBus(resultBus)
  );

endmodule

// File: rtl/bmac_checker.sv
module bmac_checker #(
  parameter int NEURONS = 4,
  parameter int ADDR_W  = 8,
  parameter int ACC_W   = 34
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cmdValid,
  input logic [3:0]               cmdOp,
  input logic [ADDR_W-1:0]        cmdArg,
  input logic [ADDR_W-1:0]        wAddr,
  input logic [NEURONS*ACC_W-1:0] resultBus
);

  logic isSet, isAdv, isSnap;
  assign isSet  = cmdValid && (cmdOp == 4'd1);
  assign isAdv  = cmdValid && ((cmdOp == 4'd2) || (cmdOp == 4'd7));
  assign isSnap = cmdValid && (cmdOp == 4'd5);

  // R2
  p_set_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    isSet |=> wAddr == $past(cmdArg));

  // R3 / R6
  p_advance_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    isAdv |=> wAddr == ADDR_W'($past(wAddr) + 1'b1));

  // R10
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(isSet || isAdv) |=> $stable(wAddr));

  // R8
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !isSnap |=> $stable(resultBus));

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (!rstN || (wAddr == '0 && resultBus == '0)) || isSet || isAdv || isSnap);

endmodule

bind bcast_mac_array bmac_checker #(
  .NEURONS(NEURONS), .ADDR_W(ADDR_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdArg(cmdArg), .wAddr(wAddr), .resultBus(resultBus)
);

// File: tb/bcast_mac_array_bench.sv
`timescale 1ns/1ps
module bcast_mac_array_bench;

  localparam int N    = 4;
  localparam int AW   = 8;
  localparam int DW   = 16;
  localparam int WW   = 10;
  localparam int ACCW = 34;
  localparam int RW   = N * ACCW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [3:0]    cmdOp = '0;
  logic [AW-1:0] cmdArg = '0;
  logic [DW-1:0] dataIn = '0;
  logic [WW-1:0] wrData = '0;
  logic [AW-1:0] wAddr;
  logic [RW-1:0] resultBus;

  always #5 clk = ~clk;

  bcast_mac_array u_bcast_mac_array (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .dataIn(dataIn), .wrData(wrData),
    .wAddr(wAddr), .resultBus(resultBus)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference model
  logic [WW-1:0]   mW [N][256];
  logic [ACCW-1:0] mAcc [N];
  logic [AW-1:0]   mAddr = '0;
  logic [RW-1:0]   lastRes = '0;

  logic [RW-1:0] expQ [$];
  string         tagQ [$];

  task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: drives one command from a falling edge, updates model, pushes expectations
  task automatic issue(input logic [3:0] op, input logic [AW-1:0] arg,
                       input logic [DW-1:0] d, input logic [WW-1:0] wd, input string tag);
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg; dataIn = d; wrData = wd;
    case (op)
      4'd1: mAddr = arg;
      4'd2: mAddr = mAddr + 1'b1;
      4'd3: if (int'(arg) < N) mW[arg][mAddr] = wd;
      4'd4: for (int i = 0; i < N; i++) mAcc[i] = '0;
      4'd5: begin
        logic [RW-1:0] v;
        for (int i = 0; i < N; i++) v[i*ACCW +: ACCW] = mAcc[i];
        expQ.push_back(v);
        tagQ.push_back(tag);
        lastRes = v;
      end
      4'd6, 4'd7: begin
        for (int i = 0; i < N; i++) begin
          longint p;
          p = longint'($signed(d)) * longint'($signed(mW[i][mAddr]));
          mAcc[i] = mAcc[i] + p[ACCW-1:0];
        end
        if (op == 4'd7) mAddr = mAddr + 1'b1;
      end
      default: ;
    endcase
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // monitor: compares snapshot results one cycle after the snapshot strobe
  logic snapSeen = 1'b0;
  always @(posedge clk) snapSeen <= rstN && cmdValid && (cmdOp == 4'd5);
  always @(negedge clk) begin
    if (snapSeen) begin
      logic [RW-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(resultBus == e, t, resultBus, e);
    end
  end

  task automatic chkAddr(input string tag);
    chk(wAddr == mAddr, tag, RW'(wAddr), RW'(mAddr));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mAcc[i] = '0;
      for (int a = 0; a < 256; a++) mW[i][a] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(wAddr == '0, "R1 pointer after reset", RW'(wAddr), '0);
    chk(resultBus == '0, "R1 results after reset", resultBus, '0);

    issue(4'd1, 8'd10, '0, '0, "");
    chkAddr("R2 set pointer");

    // R4: per-element weights at 10..13, extremes included
    for (int a = 10; a < 14; a++) begin
      issue(4'd1, AW'(a), '0, '0, "");
      for (int i = 0; i < N; i++)
        issue(4'd3, AW'(i), '0, WW'((a * 37 + i * 101) - 300), "");
    end
    issue(4'd1, 8'd12, '0, '0, "");
    issue(4'd3, 8'd0, '0, 10'h200, "");   // -512
    issue(4'd3, 8'd3, '0, 10'h1FF, "");   // 511
    issue(4'd3, 8'd5, '0, 10'h155, "");   // out of range element: ignored (R4)

    // R5 R6 R7 R8: compute-and-advance sweep
    issue(4'd1, 8'd10, '0, '0, "");
    issue(4'd4, '0, '0, '0, "");
    issue(4'd7, '0, 16'sd1234, '0, "");
    issue(4'd7, '0, -16'sd777, '0, "");
    issue(4'd7, '0, 16'h8000, '0, "");
    issue(4'd7, '0, 16'h7FFF, '0, "");
    chkAddr("R6 pointer after four compute-and-advance");
    issue(4'd5, '0, '0, '0, "R6 R4 sweep snapshot");
    @(negedge clk);

    // R5: compute without advance at fixed pointer
    issue(4'd1, 8'd12, '0, '0, "");
    issue(4'd6, '0, -16'sd32000, '0, "");
    issue(4'd6, '0, 16'sd5, '0, "");
    chkAddr("R5 pointer unchanged by compute");
    issue(4'd5, '0, '0, '0, "R5 compute snapshot");
    @(negedge clk);

    // R10: undefined opcode and idle strobe
    issue(4'd9, 8'd33, 16'sd999, 10'h3, "");
    issue(4'd0, 8'd44, 16'sd999, 10'h3, "");
    chkAddr("R10 pointer unchanged by undefined opcode");
    cmdValid = 1'b0; cmdOp = 4'd5; cmdArg = 8'd1;
    @(negedge clk);
    cmdOp = 4'd4;
    @(negedge clk);
    cmdOp = '0;
    chk(resultBus == lastRes, "R10 results unchanged with valid low", resultBus, lastRes);
    chkAddr("R10 pointer unchanged with valid low");
    issue(4'd5, '0, '0, '0, "R10 accumulators untouched");
    @(negedge clk);

    // R3: wrap of pointer
    issue(4'd1, 8'd255, '0, '0, "");
    for (int i = 0; i < N; i++) issue(4'd3, AW'(i), '0, WW'(i + 1), "");
    issue(4'd2, '0, '0, '0, "");
    chkAddr("R3 advance wraps 255 to 0");
    issue(4'd1, 8'd255, '0, '0, "");
    issue(4'd4, '0, '0, '0, "");
    issue(4'd7, '0, 16'sd3, '0, "");
    chkAddr("R6 compute-and-advance wraps");
    issue(4'd5, '0, '0, '0, "R6 weight at 255 used");
    @(negedge clk);

    // R9: overflow wraps
    issue(4'd1, 8'd50, '0, '0, "");
    for (int i = 0; i < N; i++) issue(4'd3, AW'(i), '0, 10'h200, "");
    issue(4'd4, '0, '0, '0, "");
    for (int k = 0; k < 513; k++) issue(4'd6, '0, 16'h8000, '0, "");
    issue(4'd5, '0, '0, '0, "R9 accumulator wrap");
    @(negedge clk);

    // R7: clear then snapshot gives zero
    issue(4'd4, '0, '0, '0, "");
    issue(4'd5, '0, '0, '0, "R7 clear");
    @(negedge clk);
    @(negedge clk);

    summary();
  end

endmodule